// File: doc/BRIEF.md
# Unary Maximum-Extraction Sorter

This block sorts a set of N unsigned W-bit numbers into descending order with no pairwise comparator between elements. After a load, one shared down counter sweeps from the top of the value range towards zero. Against that counter, each stored element behaves as a right-aligned unary bit-stream. The stream of element i reads 1 in any cycle where its value is greater than the counter. So 0.8, 0.4 and 0.2 on a five-bit scale give 01111, 00011 and 00001.

The first cycle in which an element's stream turns to 1 marks that element as the next maximum. It is latched into a per-element flag. A population count of the flags set in that step tells the controller how many elements share the value. The controller then stops the sweep and drains those elements one per cycle through a lowest-index priority encoder and an output multiplexer. It then resumes the sweep without reloading the counter. Elements equal to zero never raise their stream. Once the counter has reached zero they are drained in index order, and the run completes.

A caller loads all values in parallel with a one-cycle start pulse. It then collects a serial stream of value/index pairs, each marked by a valid strobe, until the done flag rises.

Top module: `unary_max_sorter`

## Requirements
- R1: Out of reset, `done` and `outValid` are both 0.
- R2: A start accepted while idle or done produces exactly N `outValid` pulses. `done` rises in the same cycle as the last pulse, and no further pulse follows while `done` is high.
- R3: The values on `outData` over one run never increase from one pulse to the next.
- R4: Elements of equal value come out in ascending index order.
- R5: On every pulse, `outIndex` is the position of the element in the loaded `inData` (element i at bits i*W+W-1 down to i*W), and `outData` equals that element's loaded value.
- R6: Elements of value zero come out after all nonzero elements, in ascending index order.
- R7: A start pulse while a run is in progress is ignored. The output sequence stays that of the values loaded at the accepted start.
- R8: `done` stays high, with `outValid` low, until the next start; that next start begins a new run.
- R9: The first pulse appears 2^W+2-M rising edges after the edge that accepts start, where M is the largest loaded value and M>0. When every value is zero, it appears 2^W+1 edges after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load pulse; sampled only when idle or done |
| inData | input | N*W | All N values side by side, element i at bits [i*W +: W] |
| outValid | output | 1 | One-cycle strobe marking a sorted element |
| outData | output | W | Value of the element being emitted |
| outIndex | output | clog2(N) | Load position of the element being emitted |
| done | output | 1 | High once all N elements have been emitted |

## Verification
The sweep counter, the flags, the pending drain set and the tie counter each show up at the ports when they go wrong. A counter that skips a step or a wrong unary compare moves the first pulse away from its predicted edge, or puts a smaller value ahead of a larger one at the next pulse. A lost or doubled flag makes a pulse count other than N by the time `done` rises. A bad drain mask repeats an index or breaks ascending order among ties within one pulse. The bench therefore checks the timing of the first output and the full value/index sequence of each run, and it checks that `done` coincides with the last pulse.

// File: rtl/unary_sort_pkg.sv
package unary_sort_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIND = 2'd1,
    ST_PUT  = 2'd2,
    ST_DONE = 2'd3
  } sortState_e;

  // strobes from the controller into the datapath
  typedef struct packed {
    logic load;        // capture inputs, reset sweep
    logic step;        // advance the shared down counter
    logic capture;     // latch the new hits into flags and pending set
    logic captureRest; // move every unflagged (zero) element to pending
    logic emit;        // output lowest pending element and mask it
  } sortCtrl_t;

endpackage

// File: rtl/lowest_index_encoder.sv
module lowest_index_encoder #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/unary_sort_datapath.sv
module unary_sort_datapath
  import unary_sort_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  sortCtrl_t       ctrl,
  input  logic [N*W-1:0]  inData,
  output logic [CW-1:0]   hitCount,
  output logic [CW-1:0]   restCount,
  output logic            cntZero,
  output logic            outValid,
  output logic [W-1:0]    outData,
  output logic [IW-1:0]   outIndex
);

  logic [W-1:0]  sweepCnt;
  logic [W-1:0]  vals [N];
  logic [N-1:0]  unaryBit;
  logic [N-1:0]  hits;
  logic [N-1:0]  flags;
  logic [N-1:0]  pending;
  logic [IW-1:0] selIdx;

  // per-element storage and unary stream generation
  for (genvar g = 0; g < N; g++) begin : g_elem
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         vals[g] <= '0;
      else if (ctrl.load) vals[g] <= inData[g*W +: W];
    end
    assign unaryBit[g] = (vals[g] > sweepCnt);
    assign hits[g]     = unaryBit[g] & ~flags[g];
  end

  assign cntZero = (sweepCnt == '0);

  always_comb begin
    hitCount  = '0;
    restCount = '0;
    for (int i = 0; i < N; i++) begin
      hitCount  = hitCount + CW'(hits[i]);
      restCount = restCount + CW'(~flags[i]);
    end
  end

  lowest_index_encoder #(.N(N)) enc_i (
    .req (pending),
    .idx (selIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweepCnt <= '0;
      flags    <= '0;
      pending  <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outIndex <= '0;
    end else begin
      outValid <= ctrl.emit;
      if (ctrl.load) begin
        sweepCnt <= '1;
        flags    <= '0;
        pending  <= '0;
      end else begin
        if (ctrl.step && !cntZero) sweepCnt <= sweepCnt - 1'b1;
        if (ctrl.capture) begin
          flags   <= flags | hits;
          pending <= hits;
        end else if (ctrl.captureRest) begin
          pending <= ~flags;
          flags   <= '1;
        end else if (ctrl.emit) begin
          pending[selIdx] <= 1'b0;
        end
      end
      if (ctrl.emit) begin
        outData  <= vals[selIdx];
        outIndex <= selIdx;
      end
    end
  end

endmodule

// File: rtl/unary_sort_ctrl.sv
module unary_sort_ctrl
  import unary_sort_pkg::*;
#(
  parameter int N = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] hitCount,
  input  logic [CW-1:0] restCount,
  input  logic          cntZero,
  output sortCtrl_t     ctrl,
  output logic          done
);

  sortState_e    state, stateNext;
  logic [CW-1:0] putLeft, putNext;
  logic          lastBatch, lastNext;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    putNext   = putLeft;
    lastNext  = lastBatch;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ctrl.load = 1'b1;
          stateNext = ST_FIND;
        end
      end
      ST_FIND: begin
        ctrl.step = 1'b1;
        if (hitCount != '0) begin
          ctrl.capture = 1'b1;
          putNext      = hitCount;
          lastNext     = 1'b0;
          stateNext    = ST_PUT;
        end else if (cntZero) begin
          if (restCount != '0) begin
            ctrl.captureRest = 1'b1;
            putNext          = restCount;
            lastNext         = 1'b1;
            stateNext        = ST_PUT;
          end else begin
            stateNext = ST_DONE;
          end
        end
      end
      ST_PUT: begin
        ctrl.emit = 1'b1;
        putNext   = putLeft - 1'b1;
        if (putLeft == CW'(1)) begin
          stateNext = (lastBatch || restCount == '0) ? ST_DONE : ST_FIND;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      putLeft   <= '0;
      lastBatch <= 1'b0;
    end else begin
      state     <= stateNext;
      putLeft   <= putNext;
      lastBatch <= lastNext;
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/unary_max_sorter.sv
module unary_max_sorter
  import unary_sort_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N*W-1:0] inData,
  output logic           outValid,
  output logic [W-1:0]   outData,
  output logic [IW-1:0]  outIndex,
  output logic           done
);

  sortCtrl_t     ctrl;
  logic [CW-1:0] hitCount;
  logic [CW-1:0] restCount;
  logic          cntZero;

  unary_sort_ctrl #(.N(N)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .hitCount  (hitCount),
    .restCount (restCount),
    .cntZero   (cntZero),
    .ctrl      (ctrl),
    .done      (done)
  );

  unary_sort_datapath #(.N(N), .W(W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .inData    (inData),
    .hitCount  (hitCount),
    .restCount (restCount),
    .cntZero   (cntZero),
    .outValid  (outValid),
    .outData   (outData),
    .outIndex  (outIndex)
  );

endmodule

// File: rtl/unary_max_sorter_chk.sv
module unary_max_sorter_chk #(
  parameter int N = 8,
  parameter int W = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic [N*W-1:0] inData,
  input logic           outValid,
  input logic [W-1:0]   outData,
  input logic [IW-1:0]  outIndex,
  input logic           done
);

  logic          busyC;
  logic          accepted;
  logic          haveLast;
  logic [W-1:0]  lastVal;
  logic [IW-1:0] lastIdx;
  logic [31:0]   emitted;
  logic [W-1:0]  shadow [N];

  assign accepted = start && !busyC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyC    <= 1'b0;
      haveLast <= 1'b0;
      lastVal  <= '0;
      lastIdx  <= '0;
      emitted  <= '0;
      for (int i = 0; i < N; i++) shadow[i] <= '0;
    end else begin
      if (accepted) begin
        busyC    <= 1'b1;
        haveLast <= 1'b0;
        emitted  <= '0;
        for (int i = 0; i < N; i++) shadow[i] <= inData[i*W +: W];
      end else begin
        if (done) busyC <= 1'b0;
        if (outValid) begin
          haveLast <= 1'b1;
          lastVal  <= outData;
          lastIdx  <= outIndex;
          emitted  <= emitted + 1;
        end
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!done && !outValid));

  assert_order_desc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && haveLast) |-> (outData <= lastVal));

  assert_tie_index_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && haveLast && outData == lastVal) |-> (outIndex > lastIdx));

  assert_data_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData == shadow[outIndex]));

  assert_count_at_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (outValid && (emitted + 1 == N)));

  assert_quiet_after_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(done)) |-> !outValid);

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

endmodule

bind unary_max_sorter unary_max_sorter_chk #(.N(N), .W(W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .inData   (inData),
  .outValid (outValid),
  .outData  (outData),
  .outIndex (outIndex),
  .done     (done)
);

// File: tb/unary_max_sorter_tb_top.sv
module unary_max_sorter_tb_top;

  localparam int N  = 8;
  localparam int W  = 4;
  localparam int IW = $clog2(N);
  localparam int MAXV = (1 << W) - 1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] inData = '0;
  logic           outValid;
  logic [W-1:0]   outData;
  logic [IW-1:0]  outIndex;
  logic           done;

  int compared = 0;
  int mismatched = 0;
  int cur [N];
  int alt [N];
  int lfsr = 32'h1d3a;

  always #5 clk = ~clk;

  unary_max_sorter #(.N(N), .W(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .inData(inData),
    .outValid(outValid), .outData(outData), .outIndex(outIndex), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] packVals(input int v [N]);
    logic [N*W-1:0] p;
    p = '0;
    for (int i = 0; i < N; i++) p[i*W +: W] = W'(v[i]);
    return p;
  endfunction

  // run one sort of cur[]; optionally pulse start with alt[] mid-run (R7)
  task automatic runSort(input string tag, input int glitchAt);
    int expVal [N];
    int expIdx [N];
    int k, n, vmax, expFirst, firstAt, guard;
    k = 0; vmax = 0;
    for (int v = MAXV; v >= 0; v--)
      for (int i = 0; i < N; i++)
        if (cur[i] == v) begin expVal[k] = v; expIdx[k] = i; k++; end
    for (int i = 0; i < N; i++) if (cur[i] > vmax) vmax = cur[i];
    expFirst = (vmax == 0) ? (1 << W) + 1 : (1 << W) + 2 - vmax;

    @(negedge clk);
    inData = packVals(cur);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0; n = 0; firstAt = -1; guard = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (start) start = 1'b0;
      if (n == glitchAt) begin
        inData = packVals(alt);
        start = 1'b1;
      end
      if (outValid) begin
        if (firstAt < 0) firstAt = n;
        if (k < N) begin
          check(outData == W'(expVal[k]), "R3", {tag, " value"}, outData, expVal[k]);
          check(outIndex == IW'(expIdx[k]), "R4", {tag, " index"}, outIndex, expIdx[k]);
        end
        k++;
      end
      if (done) begin
        check(outValid, "R2", {tag, " done with last pulse"}, outValid, 1);
        break;
      end
      guard++;
      if (guard > 1000) begin
        check(0, "R2", {tag, " watchdog"}, guard, 0);
        break;
      end
    end
    start = 1'b0;
    check(k == N, "R2", {tag, " pulse count"}, k, N);
    check(firstAt == expFirst, "R9", {tag, " first output edge"}, firstAt, expFirst);
  endtask

  task automatic testReset();
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
  endtask

  task automatic testDistinct();
    cur = '{4, 9, 1, 13, 6, 10, 2, 7};
    runSort("R3 distinct", -1);
  endtask

  task automatic testTies();
    cur = '{6, 3, 12, 9, 3, 12, 9, 3};
    runSort("R4 ties", -1);
  endtask

  task automatic testZeros();
    cur = '{0, 5, 0, 5, 0, 2, 0, 7};
    runSort("R6 zeros", -1);
    cur = '{0, 0, 0, 0, 0, 0, 0, 0};
    runSort("R6 all zero", -1);
  endtask

  task automatic testAllMax();
    for (int i = 0; i < N; i++) cur[i] = MAXV;
    runSort("R9 all max", -1);
    cur = '{1, 0, 1, 0, 0, 1, 0, 0};
    runSort("R5 ones", -1);
  endtask

  task automatic testIgnoredStart();
    cur = '{3, 8, 8, 1, 14, 0, 5, 8};
    alt = '{15, 15, 15, 15, 15, 15, 15, 15};
    runSort("R7 busy start", 5);
  endtask

  task automatic testDoneHold();
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check(done == 1'b1, "R8", "done held", done, 1);
      check(outValid == 1'b0, "R8", "no pulse while done", outValid, 0);
    end
    cur = '{2, 11, 11, 0, 7, 15, 4, 11};
    runSort("R8 restart", -1);
  endtask

  task automatic testPseudoRandom();
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) begin
        lfsr = lfsr ^ (lfsr << 7);
        lfsr = lfsr ^ (lfsr >>> 9);
        lfsr = lfsr ^ (lfsr << 8);
        cur[i] = lfsr & MAXV;
      end
      runSort($sformatf("R5 pattern %0d", r), -1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDistinct();
    testTies();
    testZeros();
    testAllMax();
    testIgnoredStart();
    testDoneHold();
    testPseudoRandom();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    compared++;
    mismatched++;
    $display("FAIL R2 global watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule